// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit processor bus with a 16-bit address and a banked cartridge made of a large ROM and a smaller battery-backed RAM. The processor only ever sees 32 KB of ROM space and an 8 KB RAM window. Writes into the ROM address range do not reach the ROM. They load four small control fields instead: a RAM enable, a 5-bit ROM bank number, a 2-bit auxiliary bank field and a banking-mode bit. Every bus cycle is also a read. The block turns the bus address into a physical ROM address of up to 21 bits. For the RAM window it returns a byte from its own RAM, or 0xFF when the RAM is gated off.

The ROM bank count and the RAM size are static configuration inputs. The auxiliary field serves three purposes, depending on mode and sizes. It supplies ROM bank bits 6:5 for the upper ROM window. In mode 1 it chooses the bank seen through the lower ROM window. In mode 1 with 32 KB RAM it picks the RAM bank.

All read results are registered and appear one clock after the address is presented. A flag tells the processor whether the cycle's data comes from the internal RAM or from the ROM at the given address. The RAM storage depth is a parameter: a byte lives at the translated offset modulo the storage size.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 1, the auxiliary field is 0, the mode is 0 and the RAM is disabled. So a read of 0x4000 gives ROM address 0x04000, a read of 0x0000 gives 0x00000, and a read of 0xA000 gives 0xFF.
- R2: A write with bus_addr[15:13]=000 enables the RAM when data[3:0] is 0xA and disables it for any other value.
- R3: A write with bus_addr[15:13]=001 loads the ROM bank field. Data 0x00 is stored as 1. Any other value is stored as data AND the size mask, so a nonzero value that masks to zero selects bank 0.
- R4: cfg_rom_log2 holds log2 of the bank count (1 to 7). The size mask is 0x01 for codes 0 and 1, 0x03 for 2, 0x07 for 3, 0x0F for 4, and 0x1F for 5 to 7.
- R5: A write with bus_addr[15:13]=010 stores data[1:0] in the auxiliary field. A write with bus_addr[15:13]=011 sets the mode to data[0].
- R6: A read below 0x4000 uses bank 0 in mode 0. In mode 1 it uses the auxiliary field times 32 for code 7, auxiliary bit 0 times 32 for code 6, and 0 otherwise.
- R7: A read in 0x4000-0x7FFF uses (ROM bank AND mask). For code 6, bit 5 comes from auxiliary bit 0. For code 7, bits 6:5 come from the auxiliary field.
- R8: For a ROM read, rom_addr is bank*0x4000 + bus_addr[13:0] and rd_from_ram is 0. Both appear one clock after the address.
- R9: In 0xA000-0xBFFF with the RAM disabled, rd_data is 0xFF and writes change no stored byte. rd_from_ram is 1 for every read in this window.
- R10: cfg_ram_kind selects the RAM: 0 is 2 KB, 1 is 8 KB, 2 is 32 KB. ram_off is (bus_addr-0xA000) mod 2 KB for kind 0 and mod 8 KB for kind 1. For kind 2 it is aux*0x2000 plus the offset in mode 1, and the offset alone in mode 0. A byte is stored at ram_off modulo the storage depth.
- R11: cfg_ram_kind 3 means no RAM: reads in the RAM window give 0xFF with ram_off 0, and writes are dropped.
- R12: When a write and a read fall in the same cycle, the registered read result reflects the state before that write.
- R13: Addresses 0x8000-0x9FFF and 0xC000-0xFFFF read as rd_data 0xFF, rom_addr 0, ram_off 0 and rd_from_ram 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rom_log2 | input | 3 | log2 of the ROM bank count |
| cfg_ram_kind | input | 2 | RAM size code: 0 2 KB, 1 8 KB, 2 32 KB, 3 none |
| bus_addr | input | 16 | Processor address, read every cycle |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered RAM read data, or 0xFF |
| rd_from_ram | output | 1 | 1 when the registered cycle hit the RAM window |
| rom_addr | output | 21 | Registered physical ROM address |
| ram_off | output | 15 | Registered translated RAM offset |

## Verification
Every bus cycle is a read, so a write to a control field or to RAM always shares a cycle with the translation of that same address. This is the case most likely to go wrong. The random stimulus sets the write strobe on about half of the cycles and spreads addresses over all windows. The directed cases load the bank field, the auxiliary field and a RAM byte in a cycle whose read result is checked. Each result is judged against a bench model that computes the expected output from the state before the write and applies the write afterwards.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  localparam int CPU_AW    = 16;
  localparam int DW        = 8;
  localparam int WIN_W     = 14;
  localparam int LOBANK_W  = 5;
  localparam int AUX_W     = 2;
  localparam int BANK_W    = LOBANK_W + AUX_W;
  localparam int ROM_AW    = WIN_W + BANK_W;
  localparam int RAMWIN_W  = 13;
  localparam int RAM_OFF_W = RAMWIN_W + AUX_W;
  localparam int SIZE_W    = 3;

  typedef enum logic [1:0] {
    RAM_2K   = 2'd0,
    RAM_8K   = 2'd1,
    RAM_32K  = 2'd2,
    RAM_NONE = 2'd3
  } ram_kind_e;

  typedef enum logic [1:0] {
    RG_ROM_LO,
    RG_ROM_HI,
    RG_RAM,
    RG_OTHER
  } region_e;

  typedef struct packed {
    logic                ram_en;
    logic [LOBANK_W-1:0] rom_bank;
    logic [AUX_W-1:0]    aux;
    logic                mode;
  } ctl_t;

  function automatic region_e decode_region(input logic [CPU_AW-1:0] a);
    if (!a[15])               return a[14] ? RG_ROM_HI : RG_ROM_LO;
    else if (a[15:13] == 3'b101) return RG_RAM;
    else                      return RG_OTHER;
  endfunction

  function automatic logic [LOBANK_W-1:0] size_mask(input logic [SIZE_W-1:0] lg);
    case (lg)
      3'd0, 3'd1: return 5'h01;
      3'd2:       return 5'h03;
      3'd3:       return 5'h07;
      3'd4:       return 5'h0F;
      default:    return 5'h1F;
    endcase
  endfunction

  function automatic logic [LOBANK_W-1:0] next_rom_bank(input logic [DW-1:0] d,
                                                        input logic [SIZE_W-1:0] lg);
    if (d == '0) return LOBANK_W'(1);
    return d[LOBANK_W-1:0] & size_mask(lg);
  endfunction

  function automatic logic [BANK_W-1:0] low_window_bank(input ctl_t c,
                                                        input logic [SIZE_W-1:0] lg);
    if (!c.mode)       return '0;
    if (lg == 3'd7)    return {c.aux, {LOBANK_W{1'b0}}};
    if (lg == 3'd6)    return {1'b0, c.aux[0], {LOBANK_W{1'b0}}};
    return '0;
  endfunction

  function automatic logic [BANK_W-1:0] high_window_bank(input ctl_t c,
                                                         input logic [SIZE_W-1:0] lg);
    logic [LOBANK_W-1:0] base;
    base = c.rom_bank & size_mask(lg);
    if (lg == 3'd7) return {c.aux, base};
    if (lg == 3'd6) return {1'b0, c.aux[0], base};
    return {{AUX_W{1'b0}}, base};
  endfunction

  function automatic logic [RAM_OFF_W-1:0] ram_offset(input logic [CPU_AW-1:0] a,
                                                      input ram_kind_e k,
                                                      input ctl_t c);
    case (k)
      RAM_2K:  return {4'b0, a[10:0]};
      RAM_8K:  return {{AUX_W{1'b0}}, a[RAMWIN_W-1:0]};
      RAM_32K: return c.mode ? {c.aux, a[RAMWIN_W-1:0]}
                             : {{AUX_W{1'b0}}, a[RAMWIN_W-1:0]};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CPU_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [SIZE_W-1:0] rom_log2,
  output ctl_t              ctl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q.ram_en   <= 1'b0;
      ctl_q.rom_bank <= LOBANK_W'(1);
      ctl_q.aux      <= '0;
      ctl_q.mode     <= 1'b0;
    end else if (wr && !addr[15]) begin
      case (addr[14:13])
        2'd0: ctl_q.ram_en   <= (wdata[3:0] == 4'hA);
        2'd1: ctl_q.rom_bank <= next_rom_bank(wdata, rom_log2);
        2'd2: ctl_q.aux      <= wdata[AUX_W-1:0];
        default: ctl_q.mode  <= wdata[0];
      endcase
    end
  end
endmodule

// File: rtl/cart_bank_xlate.sv
module cart_bank_xlate
  import cart_bank_pkg::*;
(
  input  logic [CPU_AW-1:0]    addr,
  input  ctl_t                 ctl,
  input  logic [SIZE_W-1:0]    rom_log2,
  input  ram_kind_e            ram_kind,
  output region_e              region,
  output logic [ROM_AW-1:0]    rom_addr,
  output logic [RAM_OFF_W-1:0] ram_off
);
  always_comb begin
    region   = decode_region(addr);
    rom_addr = '0;
    ram_off  = '0;
    case (region)
      RG_ROM_LO: rom_addr = {low_window_bank(ctl, rom_log2), addr[WIN_W-1:0]};
      RG_ROM_HI: rom_addr = {high_window_bank(ctl, rom_log2), addr[WIN_W-1:0]};
      RG_RAM:    ram_off  = ram_offset(addr, ram_kind, ctl);
      default:   ;
    endcase
  end
endmodule

// File: rtl/cart_bank_ram.sv
module cart_bank_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int RAM_AW = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SIZE_W-1:0]    cfg_rom_log2,
  input  logic [1:0]           cfg_ram_kind,
  input  logic [CPU_AW-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        rd_data,
  output logic                 rd_from_ram,
  output logic [ROM_AW-1:0]    rom_addr,
  output logic [RAM_OFF_W-1:0] ram_off
);
  ctl_t                 ctl_q;
  region_e              region_c;
  logic [ROM_AW-1:0]    rom_c;
  logic [RAM_OFF_W-1:0] off_c;
  logic [DW-1:0]        ram_q;
  logic                 hit_q;
  ram_kind_e            kind;

  // named events for the checker
  logic                ram_hit_w;
  logic                ram_we_w;
  logic                ram_en_w;
  logic                mode_w;
  logic [LOBANK_W-1:0] rom_bank_w;

  assign kind       = ram_kind_e'(cfg_ram_kind);
  assign ram_en_w   = ctl_q.ram_en;
  assign mode_w     = ctl_q.mode;
  assign rom_bank_w = ctl_q.rom_bank;
  assign ram_hit_w  = (region_c == RG_RAM) && ctl_q.ram_en && (kind != RAM_NONE);
  assign ram_we_w   = bus_wr && ram_hit_w;

  cart_bank_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rom_log2 (cfg_rom_log2),
    .ctl_q    (ctl_q)
  );

  cart_bank_xlate u_xlate (
    .addr     (bus_addr),
    .ctl      (ctl_q),
    .rom_log2 (cfg_rom_log2),
    .ram_kind (kind),
    .region   (region_c),
    .rom_addr (rom_c),
    .ram_off  (off_c)
  );

  cart_bank_ram #(.AW(RAM_AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we_w),
    .addr  (off_c[RAM_AW-1:0]),
    .wdata (bus_wdata),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q       <= 1'b0;
      rd_from_ram <= 1'b0;
      rom_addr    <= '0;
      ram_off     <= '0;
    end else begin
      hit_q       <= ram_hit_w;
      rd_from_ram <= (region_c == RG_RAM);
      rom_addr    <= rom_c;
      ram_off     <= off_c;
    end
  end

  assign rd_data = hit_q ? ram_q : '1;
endmodule

// File: rtl/cart_bank_chk.sv
module cart_bank_chk
  import cart_bank_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [CPU_AW-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic [DW-1:0]        bus_wdata,
  input logic [1:0]           cfg_ram_kind,
  input logic [DW-1:0]        rd_data,
  input logic                 rd_from_ram,
  input logic [ROM_AW-1:0]    rom_addr,
  input logic [RAM_OFF_W-1:0] ram_off,
  input logic                 ram_en_w,
  input logic                 mode_w,
  input logic [LOBANK_W-1:0]  rom_bank_w
);
  logic in_ram, in_other;
  assign in_ram   = (bus_addr[15:13] == 3'b101);
  assign in_other = bus_addr[15] && !in_ram;

  assert_ram_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:13] == 3'b000) |=> (ram_en_w == ($past(bus_wdata[3:0]) == 4'hA)));

  assert_zero_bank_remap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:13] == 3'b001 && bus_wdata == 8'h00) |=> (rom_bank_w == 5'd1));

  assert_low_mode0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15:14] == 2'b00 && !mode_w) |=> (rom_addr == {7'd0, $past(bus_addr[13:0])}));

  assert_rom_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_addr[15]) |=> !rd_from_ram);

  assert_ram_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ram && !ram_en_w) |=> (rd_data == 8'hFF && rd_from_ram));

  assert_no_ram_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ram && cfg_ram_kind == 2'd3) |=> (rd_data == 8'hFF && ram_off == '0));

  assert_unmapped_R13: assert property (@(posedge clk) disable iff (!rst_n)
    in_other |=> (rd_data == 8'hFF && rom_addr == '0 && ram_off == '0 && !rd_from_ram));
endmodule

bind cart_bank_ctrl cart_bank_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .cfg_ram_kind (cfg_ram_kind),
  .rd_data      (rd_data),
  .rd_from_ram  (rd_from_ram),
  .rom_addr     (rom_addr),
  .ram_off      (ram_off),
  .ram_en_w     (ram_en_w),
  .mode_w       (mode_w),
  .rom_bank_w   (rom_bank_w)
);

// File: tb/cart_bank_ctrl_tb.sv
`timescale 1ns/1ps
module cart_bank_ctrl_tb;
  localparam int STORE = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_rom_log2 = 3'd5;
  logic [1:0]  cfg_ram_kind = 2'd0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  rd_data;
  logic        rd_from_ram;
  logic [20:0] rom_addr;
  logic [14:0] ram_off;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state
  int m_en = 0, m_bank = 1, m_aux = 0, m_mode = 0;
  byte unsigned m_mem [STORE];

  always #10 clk = ~clk;

  cart_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_rom_log2(cfg_rom_log2), .cfg_ram_kind(cfg_ram_kind),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .rd_from_ram(rd_from_ram), .rom_addr(rom_addr), .ram_off(ram_off)
  );

  function automatic int e_mask(int lg);
    if (lg >= 5) return 31;
    if (lg <= 1) return 1;
    return (1 << lg) - 1;
  endfunction

  function automatic bit is_ram(int a);
    return a >= 'hA000 && a < 'hC000;
  endfunction

  function automatic int e_rom(int a);
    int b, lg;
    lg = int'(cfg_rom_log2);
    if (a < 'h4000) begin
      b = 0;
      if (m_mode == 1 && lg == 7) b = m_aux * 32;
      else if (m_mode == 1 && lg == 6) b = (m_aux % 2) * 32;
      return b * 'h4000 + a;
    end
    if (a < 'h8000) begin
      b = m_bank & e_mask(lg);
      if (lg == 7) b = b % 32 + m_aux * 32;
      else if (lg == 6) b = b % 32 + (m_aux % 2) * 32;
      return b * 'h4000 + (a - 'h4000);
    end
    return 0;
  endfunction

  function automatic int e_off(int a);
    int o;
    if (!is_ram(a)) return 0;
    o = a - 'hA000;
    case (int'(cfg_ram_kind))
      0: return o % 2048;
      1: return o % 8192;
      2: return (m_mode == 1) ? m_aux * 8192 + o : o;
      default: return 0;
    endcase
  endfunction

  function automatic int e_data(int a);
    if (is_ram(a) && m_en == 1 && cfg_ram_kind != 2'd3) return int'(m_mem[e_off(a) % STORE]);
    return 'hFF;
  endfunction

  function automatic void model_write(int a, int d);
    if (a < 'h2000) m_en = (d % 16 == 10) ? 1 : 0;
    else if (a < 'h4000) m_bank = (d == 0) ? 1 : (d & e_mask(int'(cfg_rom_log2)));
    else if (a < 'h6000) m_aux = d % 4;
    else if (a < 'h8000) m_mode = d % 2;
    else if (is_ram(a) && m_en == 1 && cfg_ram_kind != 2'd3) m_mem[e_off(a) % STORE] = byte'(d);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: expectations from pre-write state (R12), then compare one clock later
  task automatic step(input int a, input int d, input bit w, input string tag);
    int er, eo, ed, ef;
    er = e_rom(a); eo = e_off(a); ed = e_data(a); ef = is_ram(a) ? 1 : 0;
    bus_addr = 16'(a); bus_wdata = 8'(d); bus_wr = w;
    @(posedge clk);
    if (w) model_write(a, d);
    @(negedge clk);
    bus_wr = 1'b0;
    chk(rom_addr == 21'(er) && ram_off == 15'(eo) && rd_data == 8'(ed) && rd_from_ram == ef,
        tag, $sformatf("addr 0x%04h rom/off/data/flag", a),
        int'(rom_addr) ^ (int'(rd_data) << 24), er ^ (ed << 24));
    if (rom_addr != 21'(er)) chk(1'b0, tag, "rom_addr", int'(rom_addr), er);
    if (ram_off != 15'(eo))  chk(1'b0, tag, "ram_off", int'(ram_off), eo);
    if (rd_data != 8'(ed))   chk(1'b0, tag, "rd_data", int'(rd_data), ed);
    if (rd_from_ram != ef)   chk(1'b0, tag, "rd_from_ram", int'(rd_from_ram), ef);
  endtask

  function automatic string tag_of(int a);
    if (a < 'h4000) return "R6";
    if (a < 'h8000) return "R7";
    if (is_ram(a)) return "R10";
    return "R13";
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step('h4000, 0, 0, "R1");
    step('h0000, 0, 0, "R1");
    step('hA000, 0, 0, "R1");
    // R2 enable / disable
    step('h1FFF, 'h3A, 1, "R2");
    step('hA010, 0, 0, "R2");
    step('h0000, 'hAB, 1, "R2");
    step('hA010, 0, 0, "R2");
    // R9 disabled write dropped: fill below needs enable; probe drop first
    step('h0000, 'h0A, 1, "R2");
    step('hA005, 'h5C, 1, "R10");
    step('h0000, 'h00, 1, "R2");
    step('hA005, 'h77, 1, "R9");
    step('h0000, 'h0A, 1, "R9");
    step('hA005, 0, 0, "R9");
    // fill storage in 2 KB mode
    for (int i = 0; i < STORE; i++) step('hA000 + i, (i * 37 + 11) % 256, 1, "R10");
    // R3 zero remap and masked zero
    cfg_rom_log2 = 3'd5;
    step('h2000, 'h00, 1, "R3");
    step('h4123, 0, 0, "R3");
    step('h3000, 'h20, 1, "R3");
    step('h7FFF, 0, 0, "R3");
    // R4 masks over every size code
    for (int lg = 0; lg < 8; lg++) begin
      cfg_rom_log2 = 3'(lg);
      step('h2000, 'hFF, 1, "R4");
      step('h4000, 0, 0, "R4");
    end
    // R5 / R6 / R7 with large ROMs
    cfg_rom_log2 = 3'd7;
    step('h4000, 'h03, 1, "R5");
    step('h6000, 'h01, 1, "R5");
    step('h0100, 0, 0, "R6");
    step('h5555, 0, 0, "R7");
    cfg_rom_log2 = 3'd6;
    step('h0100, 0, 0, "R6");
    step('h5555, 0, 0, "R7");
    step('h6000, 'h00, 1, "R5");
    step('h3FFF, 0, 0, "R6");
    // R8 address formula in mode 0
    cfg_rom_log2 = 3'd4;
    step('h2000, 'h0B, 1, "R8");
    step('h6ABC, 0, 0, "R8");
    // R10 32 KB banking
    cfg_ram_kind = 2'd2;
    step('h6000, 'h01, 1, "R10");
    step('h4000, 'h02, 1, "R10");
    step('hBFFF, 0, 0, "R10");
    step('h6000, 'h00, 1, "R10");
    step('hBFFF, 0, 0, "R10");
    cfg_ram_kind = 2'd1;
    step('hB234, 0, 0, "R10");
    // R11 no RAM
    cfg_ram_kind = 2'd3;
    step('hA044, 'h99, 1, "R11");
    cfg_ram_kind = 2'd0;
    step('hA044, 0, 0, "R11");
    // R12 same-cycle write and read
    step('h2000, 'h05, 1, "R12");
    step('h2000, 'h06, 1, "R12");
    step('hA123, 'hE1, 1, "R12");
    step('hA123, 'h1E, 1, "R12");
    step('hA123, 0, 0, "R12");
    // R13 unmapped windows
    step('h8000, 'h12, 1, "R13");
    step('hC000, 'h34, 1, "R13");
    step('hFFFF, 0, 0, "R13");
    step('h4000, 0, 0, "R13");
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int a, d, sel;
      bit w;
      if (n % 250 == 0) begin
        cfg_rom_log2 = 3'($urandom_range(1, 7));
        cfg_ram_kind = 2'($urandom_range(0, 3));
      end
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1, 2: a = $urandom_range('h0000, 'h7FFF);
        3, 4, 5, 6: a = $urandom_range('hA000, 'hBFFF);
        7: a = $urandom_range('h8000, 'h9FFF);
        8: a = $urandom_range('hC000, 'hFFFF);
        default: a = $urandom_range('h0000, 'h1FFF);
      endcase
      d = $urandom_range(0, 255);
      if (a < 'h2000 && $urandom_range(0, 1) == 1) d = (d & 'hF0) | 'h0A;
      w = ($urandom_range(0, 1) == 1);
      step(a, d, w, tag_of(a));
    end
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule